// File: doc/BRIEF.md
# Keyed Register Write-Protection Guard

This block sits on the write path into a register bank. It compares each bus write address against a parameterized list of guarded control registers. These include the chip-select and address/mask registers of the memory controller, the address-translation registers, the clock-gear registers and the PLL control registers. While protection is on, a write to any guarded address is suppressed and a one-cycle violation interrupt pulse follows. All other writes pass to the bank unchanged.

Software turns protection on or off with a double key spread over two key registers, KEY_A and KEY_B. The first stage is 0x5A written to KEY_A and then 0xA5 written to KEY_B. The second stage reverses the bytes: 0xA5 to KEY_A, then 0x5A to KEY_B. Completing both stages toggles the protection state. The state is driven out on `protect_o` so the register bank can expose it as a read-only status bit.

The key sequencer has four states:
- `KS_IDLE`: waiting for the first key.
- `KS_K1A`: 0x5A has been written to KEY_A.
- `KS_K1B`: the first stage is complete.
- `KS_K2A`: 0xA5 has been written to KEY_A after the first stage.

Only writes that target a key address move the sequencer. These transitions apply:
- `KS_IDLE` goes to `KS_K1A` on 0x5A written to KEY_A.
- `KS_K1A` goes to `KS_K1B` on 0xA5 written to KEY_B.
- `KS_K1B` goes to `KS_K2A` on 0xA5 written to KEY_A.
- `KS_K2A` goes to `KS_IDLE` on 0x5A written to KEY_B, and this transition toggles protection.
- Any other key write, whether it carries a wrong value or targets the wrong key register, returns the sequencer to `KS_IDLE`.

Top module: `wpg_guard`

## Requirements
- R1: While reset is asserted and after it is released, `protect_o` is 0, `viol_irq_o` is 0 and the key sequencer is in `KS_IDLE`.
- R2: With protection off, the writes 0x5A to KEY_A, 0xA5 to KEY_B, 0xA5 to KEY_A and 0x5A to KEY_B set `protect_o` to 1. The new value is visible in the cycle after the last key write and governs every bus write from then on.
- R3: Repeating the full double key while protection is on clears `protect_o` to 0, with the same timing as R2.
- R4: A key-register write with a value other than the one the current state expects returns the sequencer to `KS_IDLE`. A sequence broken this way leaves `protect_o` unchanged.
- R5: A write to the key register that is not the one expected next (out of order) returns the sequencer to `KS_IDLE`.
- R6: Bus writes to non-key addresses, and cycles with `wr_en_i` low, leave the sequencer state unchanged. A key sequence interleaved with such writes still completes.
- R7: While `protect_o` is 1, a write to any address in GUARD_LIST has `wr_en_o` held at 0 in the same cycle.
- R8: Each suppressed write produces exactly one cycle of `viol_irq_o` = 1 in the cycle after the write. Back-to-back suppressed writes give one pulse per write.
- R9: While `protect_o` is 0, writes to guarded addresses pass (`wr_en_o` = 1) and raise no interrupt.
- R10: Writes to addresses outside GUARD_LIST, including KEY_A and KEY_B, always pass, whatever the protection state.
- R11: `wr_addr_o` and `wr_data_o` always equal `wr_addr_i` and `wr_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | ADDR_W | Bus write address |
| wr_data_i | input | DATA_W | Bus write data |
| wr_en_o | output | 1 | Write strobe forwarded to the register bank |
| wr_addr_o | output | ADDR_W | Address forwarded to the register bank |
| wr_data_o | output | DATA_W | Data forwarded to the register bank |
| protect_o | output | 1 | Current protection state, for the status bit |
| viol_irq_o | output | 1 | One-cycle pulse per suppressed write |

## Verification
The bench uses the default parameters: 8-bit address and data, four guarded addresses (0x10, 0x11, 0x20, 0x30), and KEY_A/KEY_B at 0xF1/0xF2. With these values every guarded entry, both key registers and a free address (0x40) are reachable within a short walk. This lets the bench interleave free-address writes and idle cycles inside a key sequence, and break sequences by wrong value and by wrong order. It can also issue back-to-back blocked writes to the first and last list entries in both protection states. A directed reset taken while protection is on confirms that the state returns to off.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_K1A  = 2'd1,
        KS_K1B  = 2'd2,
        KS_K2A  = 2'd3
    } key_state_e;
endpackage

// File: rtl/wpg_addr_match.sv
module wpg_addr_match #(
    parameter int ADDR_W  = 8,
    parameter int N_ENTRY = 4,
    parameter logic [N_ENTRY*ADDR_W-1:0] LIST = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    logic [N_ENTRY-1:0] eq;

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
        assign eq[g] = (addr_i == LIST[g*ADDR_W +: ADDR_W]);
    end

    assign hit_o = |eq;
endmodule

// File: rtl/wpg_key_fsm.sv
module wpg_key_fsm
    import wpg_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_A_ADDR = 8'hF1,
    parameter logic [ADDR_W-1:0] KEY_B_ADDR = 8'hF2,
    parameter logic [DATA_W-1:0] PAT_LO     = 8'h5A,
    parameter logic [DATA_W-1:0] PAT_HI     = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              toggle_o
);
    key_state_e state_q, state_d;
    logic       wr_a, wr_b;

    assign wr_a = wr_en_i && (wr_addr_i == KEY_A_ADDR);
    assign wr_b = wr_en_i && (wr_addr_i == KEY_B_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        toggle_o = 1'b0;
        if (wr_a || wr_b) begin
            state_d = KS_IDLE;
            unique case (state_q)
                KS_IDLE: if (wr_a && wr_data_i == PAT_LO) state_d = KS_K1A;
                KS_K1A:  if (wr_b && wr_data_i == PAT_HI) state_d = KS_K1B;
                KS_K1B:  if (wr_a && wr_data_i == PAT_HI) state_d = KS_K2A;
                KS_K2A:  if (wr_b && wr_data_i == PAT_LO) toggle_o = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/wpg_guard.sv
module wpg_guard #(
    parameter int                        ADDR_W     = 8,
    parameter int                        DATA_W     = 8,
    parameter int                        N_GUARD    = 4,
    parameter logic [N_GUARD*ADDR_W-1:0] GUARD_LIST = {8'h30, 8'h20, 8'h11, 8'h10},
    parameter logic [ADDR_W-1:0]         KEY_A_ADDR = 8'hF1,
    parameter logic [ADDR_W-1:0]         KEY_B_ADDR = 8'hF2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              protect_o,
    output logic              viol_irq_o
);
    localparam logic [DATA_W-1:0] PAT_LO = DATA_W'(8'h5A);
    localparam logic [DATA_W-1:0] PAT_HI = DATA_W'(8'hA5);

    logic guard_hit, blocked, toggle, prot_q, irq_q;

    wpg_addr_match #(
        .ADDR_W (ADDR_W),
        .N_ENTRY(N_GUARD),
        .LIST   (GUARD_LIST)
    ) u_match (
        .addr_i(wr_addr_i),
        .hit_o (guard_hit)
    );

    wpg_key_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .KEY_A_ADDR(KEY_A_ADDR),
        .KEY_B_ADDR(KEY_B_ADDR),
        .PAT_LO    (PAT_LO),
        .PAT_HI    (PAT_HI)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .toggle_o (toggle)
    );

    assign blocked = wr_en_i && guard_hit && prot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            prot_q <= prot_q ^ toggle;
            irq_q  <= blocked;
        end
    end

    assign wr_en_o    = wr_en_i && !blocked;
    assign wr_addr_o  = wr_addr_i;
    assign wr_data_o  = wr_data_i;
    assign protect_o  = prot_q;
    assign viol_irq_o = irq_q;
endmodule

// File: rtl/wpg_guard_chk.sv
module wpg_guard_chk #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_A_ADDR = 8'hF1,
    parameter logic [ADDR_W-1:0] KEY_B_ADDR = 8'hF2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              wr_en_o,
    input logic              protect_o,
    input logic              viol_irq_o
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (!protect_o && !viol_irq_o);
        end
    end

    // R2 / R3: protection only changes right after 0x5A lands on KEY_B
    p_toggle_on_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(protect_o) |-> $past(wr_en_i && wr_addr_i == KEY_B_ADDR
                                      && wr_data_i == DATA_W'(8'h5A)));

    p_block_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_en_o) |=> viol_irq_o);

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        viol_irq_o |-> $past(wr_en_i && !wr_en_o));

    p_off_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !protect_o) |-> wr_en_o);

    p_keys_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_addr_i == KEY_A_ADDR || wr_addr_i == KEY_B_ADDR)) |-> wr_en_o);

    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |-> !wr_en_o);
endmodule

bind wpg_guard wpg_guard_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .KEY_A_ADDR(KEY_A_ADDR),
    .KEY_B_ADDR(KEY_B_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wr_en_o   (wr_en_o),
    .protect_o (protect_o),
    .viol_irq_o(viol_irq_o)
);

// File: tb/sim_wpg_guard.sv
`timescale 1ns/1ps
module sim_wpg_guard;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 30;

    // {en, addr, data, exp_wen, exp_irq_after, exp_prot_after}
    localparam logic [19:0] VEC [N_VEC] = '{
        {1'b1, 8'h10, 8'h33, 1'b1, 1'b0, 1'b0},  // R9 guarded, off
        {1'b1, 8'h40, 8'h01, 1'b1, 1'b0, 1'b0},  // R10
        {1'b1, 8'hF1, 8'h5A, 1'b1, 1'b0, 1'b0},  // R2 key 1a
        {1'b1, 8'h40, 8'h77, 1'b1, 1'b0, 1'b0},  // R6 interleaved
        {1'b0, 8'hF2, 8'h00, 1'b0, 1'b0, 1'b0},  // R6 idle bus on key addr
        {1'b1, 8'hF2, 8'hA5, 1'b1, 1'b0, 1'b0},  // R2 key 1b
        {1'b1, 8'hF1, 8'hA5, 1'b1, 1'b0, 1'b0},  // R2 key 2a
        {1'b1, 8'hF2, 8'h5A, 1'b1, 1'b0, 1'b1},  // R2 key 2b -> on
        {1'b1, 8'h10, 8'h11, 1'b0, 1'b1, 1'b1},  // R7 R8 blocked
        {1'b1, 8'h30, 8'h22, 1'b0, 1'b1, 1'b1},  // R8 back-to-back
        {1'b0, 8'h30, 8'h22, 1'b0, 1'b0, 1'b1},  // R8 pulse ends
        {1'b1, 8'h40, 8'h05, 1'b1, 1'b0, 1'b1},  // R10 free addr, on
        {1'b1, 8'hF1, 8'h5A, 1'b1, 1'b0, 1'b1},  // R4 start
        {1'b1, 8'hF2, 8'h00, 1'b1, 1'b0, 1'b1},  // R4 wrong value
        {1'b1, 8'hF1, 8'hA5, 1'b1, 1'b0, 1'b1},  // R4 rest of key
        {1'b1, 8'hF2, 8'h5A, 1'b1, 1'b0, 1'b1},  // R4 no toggle
        {1'b1, 8'hF1, 8'h5A, 1'b1, 1'b0, 1'b1},  // R5 start
        {1'b1, 8'hF1, 8'hA5, 1'b1, 1'b0, 1'b1},  // R5 wrong register
        {1'b1, 8'hF2, 8'hA5, 1'b1, 1'b0, 1'b1},  // R5
        {1'b1, 8'hF1, 8'hA5, 1'b1, 1'b0, 1'b1},  // R5
        {1'b1, 8'hF2, 8'h5A, 1'b1, 1'b0, 1'b1},  // R5 no toggle
        {1'b1, 8'h20, 8'h44, 1'b0, 1'b1, 1'b1},  // R7 still on
        {1'b1, 8'hF1, 8'h5A, 1'b1, 1'b0, 1'b1},  // R3
        {1'b1, 8'hF2, 8'hA5, 1'b1, 1'b0, 1'b1},  // R3
        {1'b1, 8'h11, 8'h66, 1'b0, 1'b1, 1'b1},  // R6 blocked write mid-key
        {1'b1, 8'hF1, 8'hA5, 1'b1, 1'b0, 1'b1},  // R3
        {1'b1, 8'hF2, 8'h5A, 1'b1, 1'b0, 1'b0},  // R3 -> off
        {1'b1, 8'h20, 8'h55, 1'b1, 1'b0, 1'b0},  // R9 off again
        {1'b1, 8'h30, 8'h56, 1'b1, 1'b0, 1'b0},  // R9
        {1'b1, 8'hF2, 8'h5A, 1'b1, 1'b0, 1'b0}   // R10 key passes
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       wr_en_o, protect_o, viol_irq_o;
    logic [7:0] wr_addr_o, wr_data_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wpg_guard u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .protect_o(protect_o), .viol_irq_o(viol_irq_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic en, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = en; wr_addr_i = a; wr_data_i = d;
        @(posedge clk);
        #1;
        wr_en_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 prot in reset", 16'(protect_o), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 prot after reset", 16'(protect_o), 16'h0);
        check("R1 irq after reset", 16'(viol_irq_o), 16'h0);

        for (int i = 0; i < N_VEC; i++) begin
            @(negedge clk);
            wr_en_i   = VEC[i][19];
            wr_addr_i = VEC[i][18:11];
            wr_data_i = VEC[i][10:3];
            #1;
            check($sformatf("R7/R9/R10 wen vec %0d", i), 16'(wr_en_o), 16'(VEC[i][2]));
            check($sformatf("R11 fwd vec %0d", i), {wr_addr_o, wr_data_o}, {wr_addr_i, wr_data_i});
            @(posedge clk); #1;
            check($sformatf("R8 irq vec %0d", i), 16'(viol_irq_o), 16'(VEC[i][1]));
            check($sformatf("R2/R3 prot vec %0d", i), 16'(protect_o), 16'(VEC[i][0]));
        end
        wr_en_i = 1'b0;

        // R2 timing: protect still 0 while final key write is on the bus
        do_write(1'b1, 8'hF1, 8'h5A);
        do_write(1'b1, 8'hF2, 8'hA5);
        do_write(1'b1, 8'hF1, 8'hA5);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 8'hF2; wr_data_i = 8'h5A;
        #1;
        check("R2 prot before edge", 16'(protect_o), 16'h0);
        @(posedge clk); #1;
        check("R2 prot after edge", 16'(protect_o), 16'h1);
        @(negedge clk);
        wr_addr_i = 8'h11; wr_data_i = 8'h99;
        #1;
        check("R7 guarded next write", 16'(wr_en_o), 16'h0);
        @(posedge clk); #1;
        wr_en_i = 1'b0;
        check("R8 pulse", 16'(viol_irq_o), 16'h1);
        @(posedge clk); #1;
        check("R8 single cycle", 16'(viol_irq_o), 16'h0);

        // R1: reset while protected
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async clear", 16'(protect_o), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 8'h10; wr_data_i = 8'h01;
        #1;
        check("R1 R9 pass after reset", 16'(wr_en_o), 16'h1);
        @(posedge clk); #1;
        wr_en_i = 1'b0;
        check("R9 no irq", 16'(viol_irq_o), 16'h0);

        // R1: sequencer idle after reset: a lone second stage does nothing
        do_write(1'b1, 8'hF1, 8'hA5);
        do_write(1'b1, 8'hF2, 8'h5A);
        check("R1 seq idle", 16'(protect_o), 16'h0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule